// File: doc/BRIEF.md
# Address Register File with Size-Aware Sign Extension

This block holds a bank of address registers, each one full address wide, with two independent read ports and one write port. Every access carries a two-bit operation-size code. A word-size write takes the low half of the source value, copies its top bit into the upper half, and always replaces the whole register. A long-word write stores the source value unchanged. A register cannot be written or read one byte at a time. A byte-size code, or the reserved size code, raises an illegal-size flag on that port.

On the read side, a word-size request returns the low half of the selected register, sign-extended to the full width. Address arithmetic downstream therefore always receives a full-width operand. A long-word request returns the whole register. Reads are combinational from the stored state. A write lands on the clock edge, so a read of the register being written in the same cycle still shows the old contents. Every register, including the highest-numbered one, behaves the same way.

Top module: `addr_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to zero. After reset, a long read of any register returns 0.
- R2: A write with size code 2'b10 (long) stores all bits of the source value in the selected register.
- R3: A write with size code 2'b01 (word) stores the low 16 source bits in bits 15:0 and copies source bit 15 into all of bits 31:16.
- R4: A write with size code 2'b00 (byte) or 2'b11 (reserved) drives the write illegal-size flag high in that cycle and leaves every register unchanged. A legal write, or no write request, keeps the flag low.
- R5: A read with size code 2'b10 returns the full contents of the selected register.
- R6: A read with size code 2'b01 returns the register's bits 15:0, with bit 15 repeated into bits 31:16.
- R7: A read with size code 2'b00 or 2'b11 drives that port's illegal-size flag high and returns zero on its data output. A legal read keeps the flag low.
- R8: A read of a register in the same cycle as a write to it returns the value held before the write. The written value appears from the next cycle on.
- R9: The two read ports are independent, and every register, including register 7, can be written and read with the same rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_sel | input | 3 | Register written |
| wr_size | input | 2 | Write size code: 01 word, 10 long, 00/11 illegal |
| wr_data | input | 32 | Source value |
| wr_illegal | output | 1 | Write request carries an illegal size |
| rd_a_sel | input | 3 | Register read on port A |
| rd_a_size | input | 2 | Port A size code |
| rd_a_data | output | 32 | Port A result |
| rd_a_illegal | output | 1 | Port A size is illegal |
| rd_b_sel | input | 3 | Register read on port B |
| rd_b_size | input | 2 | Port B size code |
| rd_b_data | output | 32 | Port B result |
| rd_b_illegal | output | 1 | Port B size is illegal |

## Verification
The bench builds the block with its default parameters: eight registers, 32 bits wide. With that configuration it can sweep every register, on both read ports, across all four size codes. It writes values whose bit 15 is both clear and set, so the sign-extension boundary is exercised in both directions on the write side and on the read side. It also overlaps writes and reads of the same register, which brings the old-value-then-new-value ordering into reach, and it repeats a reset in the middle of the run.

// File: rtl/addr_regfile.sv
module addr_regfile #(
  parameter int NREGS = 8,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(NREGS)-1:0] wr_sel,
  input  logic [1:0]               wr_size,
  input  logic [DW-1:0]            wr_data,
  output logic                     wr_illegal,
  input  logic [$clog2(NREGS)-1:0] rd_a_sel,
  input  logic [1:0]               rd_a_size,
  output logic [DW-1:0]            rd_a_data,
  output logic                     rd_a_illegal,
  input  logic [$clog2(NREGS)-1:0] rd_b_sel,
  input  logic [1:0]               rd_b_size,
  output logic [DW-1:0]            rd_b_data,
  output logic                     rd_b_illegal
);
  localparam int HW = DW / 2;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_LONG = 2'b10;

  logic [NREGS-1:0][DW-1:0] regs;
  logic                     wr_ok;
  logic [DW-1:0]            wr_ext;

  function automatic logic size_ok(input logic [1:0] sz);
    return (sz == SZ_WORD) || (sz == SZ_LONG);
  endfunction

  function automatic logic [DW-1:0] fmt(input logic [DW-1:0] v, input logic [1:0] sz);
    case (sz)
      SZ_WORD: return {{HW{v[HW-1]}}, v[HW-1:0]};
      SZ_LONG: return v;
      default: return '0;
    endcase
  endfunction

  assign wr_ok      = size_ok(wr_size);
  assign wr_illegal = wr_en & ~wr_ok;
  assign wr_ext     = fmt(wr_data, wr_size);

  always_ff @(posedge clk) begin
    if (rst)                regs <= '0;
    else if (wr_en && wr_ok) regs[wr_sel] <= wr_ext;
  end

  assign rd_a_data    = fmt(regs[rd_a_sel], rd_a_size);
  assign rd_a_illegal = ~size_ok(rd_a_size);
  assign rd_b_data    = fmt(regs[rd_b_sel], rd_b_size);
  assign rd_b_illegal = ~size_ok(rd_b_size);

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd_a_data == '0) && (rd_b_data == '0));

  assert_long_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == SZ_LONG) |=> regs[$past(wr_sel)] == $past(wr_data));

  assert_word_write_ext_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == SZ_WORD) |=>
      (regs[$past(wr_sel)][HW-1:0] == $past(wr_data[HW-1:0])) &&
      (regs[$past(wr_sel)][DW-1:HW] == {HW{$past(wr_data[HW-1])}}));

  assert_illegal_write_holds_R4: assert property (@(posedge clk) disable iff (rst)
    wr_illegal |=> $stable(regs));

  assert_no_write_holds_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs));

  assert_word_read_a_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_a_size == SZ_WORD) |-> rd_a_data[DW-1:HW] == {HW{rd_a_data[HW-1]}});

  assert_word_read_b_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_b_size == SZ_WORD) |-> rd_b_data[DW-1:HW] == {HW{rd_b_data[HW-1]}});

  assert_illegal_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_a_illegal |-> rd_a_data == '0) and (rd_b_illegal |-> rd_b_data == '0));
endmodule

// File: tb/addr_regfile_test.sv
module addr_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [2:0]  wr_sel = 0;
  logic [1:0]  wr_size = 0;
  logic [31:0] wr_data = 0;
  logic        wr_illegal;
  logic [2:0]  rd_a_sel = 0;
  logic [1:0]  rd_a_size = 0;
  logic [31:0] rd_a_data;
  logic        rd_a_illegal;
  logic [2:0]  rd_b_sel = 0;
  logic [1:0]  rd_b_size = 0;
  logic [31:0] rd_b_data;
  logic        rd_b_illegal;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [8];

  addr_regfile uut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_data(wr_data),
    .wr_illegal(wr_illegal),
    .rd_a_sel(rd_a_sel), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data),
    .rd_a_illegal(rd_a_illegal),
    .rd_b_sel(rd_b_sel), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data),
    .rd_b_illegal(rd_b_illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] expect_rd(input logic [31:0] v, input logic [1:0] sz);
    if (sz == 2'b01) return (v[15] ? 32'hFFFF_0000 : 32'h0) + {16'h0, v[15:0]};
    if (sz == 2'b10) return v;
    return 32'h0;
  endfunction

  function automatic logic legal(input logic [1:0] sz);
    return sz == 2'b01 || sz == 2'b10;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input string req, input logic we, input logic [2:0] ws, input logic [1:0] wz,
                     input logic [31:0] wd, input logic [2:0] as, input logic [1:0] az,
                     input logic [2:0] bs, input logic [1:0] bz);
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_size = wz; wr_data = wd;
    rd_a_sel = as; rd_a_size = az; rd_b_sel = bs; rd_b_size = bz;
    #1;
    check(req, "port A data", rd_a_data, expect_rd(model[as], az));
    check(req, "port B data", rd_b_data, expect_rd(model[bs], bz));
    check(req, "port A flag", {31'b0, rd_a_illegal}, {31'b0, !legal(az)});
    check(req, "port B flag", {31'b0, rd_b_illegal}, {31'b0, !legal(bz)});
    check(req, "write flag", {31'b0, wr_illegal}, {31'b0, we && !legal(wz)});
    if (we && legal(wz)) model[ws] = (wz == 2'b01) ? expect_rd(wd, 2'b01) : wd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; wr_en = 0;
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    repeat (2) @(negedge clk);
    rst = 0;
    // R1: all registers zero after reset
    for (int i = 0; i < 8; i++) cyc("R1", 0, 0, 2'b10, 0, 3'(i), 2'b10, 3'(7 - i), 2'b10);
    // R2, R5, R9: long writes to every register, read back on both ports
    for (int i = 0; i < 8; i++)
      cyc("R2", 1, 3'(i), 2'b10, 32'h8000_8001 ^ (32'h1357_9BDF * (i + 1)), 3'(i), 2'b10, 3'(i), 2'b10);
    for (int i = 0; i < 8; i++) cyc("R5", 0, 0, 2'b10, 0, 3'(i), 2'b10, 3'(7 - i), 2'b10);
    // R6, R7, R9: every size code on both ports
    for (int i = 0; i < 8; i++)
      for (int s = 0; s < 4; s++)
        cyc(s == 1 ? "R6" : (legal(2'(s)) ? "R9" : "R7"), 0, 0, 2'b10, 0, 3'(i), 2'(s), 3'(i ^ 3), 2'(3 - s));
    // R3: word writes with bit 15 clear and set
    for (int i = 0; i < 8; i++) begin
      cyc("R3", 1, 3'(i), 2'b01, {16'hA5A5, 1'b0, 15'(i * 1111)}, 0, 2'b10, 0, 2'b01);
      cyc("R3", 0, 0, 2'b10, 0, 3'(i), 2'b10, 3'(i), 2'b01);
      cyc("R3", 1, 3'(i), 2'b01, {16'h0000, 1'b1, 15'(i * 2222)}, 0, 2'b10, 0, 2'b01);
      cyc("R3", 0, 0, 2'b10, 0, 3'(i), 2'b10, 3'(i), 2'b01);
    end
    // R6: word read of a long value whose low half has bit 15 set / clear
    cyc("R6", 1, 3'd5, 2'b10, 32'h1234_F00D, 0, 2'b10, 0, 2'b10);
    cyc("R6", 1, 3'd6, 2'b10, 32'hFEDC_7AAA, 3'd5, 2'b01, 3'd5, 2'b10);
    cyc("R6", 0, 0, 2'b10, 0, 3'd6, 2'b01, 3'd5, 2'b01);
    // R4: byte and reserved writes are flagged and change nothing
    for (int i = 0; i < 8; i++) begin
      cyc("R4", 1, 3'(i), 2'b00, 32'hDEAD_BEEF, 0, 2'b10, 0, 2'b10);
      cyc("R4", 1, 3'(i), 2'b11, 32'hCAFE_F00D, 3'(i), 2'b10, 3'(i), 2'b01);
    end
    for (int i = 0; i < 8; i++) cyc("R4", 0, 3'(i), 2'b00, 32'h1, 3'(i), 2'b10, 3'(i), 2'b10);
    // R8: same-cycle write and read shows old value, new value next cycle
    for (int i = 0; i < 8; i++) begin
      cyc("R8", 1, 3'(i), 2'b10, 32'h0BAD_0000 + i, 3'(i), 2'b10, 3'(i), 2'b01);
      cyc("R8", 1, 3'(i), 2'b01, 32'h0000_9000 + i, 3'(i), 2'b10, 3'(i), 2'b10);
      cyc("R8", 0, 0, 2'b10, 0, 3'(i), 2'b10, 3'(i), 2'b01);
    end
    // R1: reset in the middle of the run
    do_reset();
    for (int i = 0; i < 8; i++) cyc("R1", 0, 0, 2'b10, 0, 3'(i), 2'b10, 3'(i), 2'b01);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule